// File: doc/BRIEF.md
# Per-CPU Interrupt Pending Register and Level Encoder

This block holds the interrupt pending word for one processor and turns it into fifteen priority level request lines, levels 1 to 15, toward that processor. The word combines several sources. Software interrupts live in the upper fifteen bits and are set and cleared through a small word-addressed register port. A level-15 broadcast bit is set and cleared by edges on a broadcast input shared by all processors. A local timer bit mirrors the processor's own timer input. When this processor is the routing target, the hard levels routed from the system interrupt unit also appear in the word.

The system-wide source mask and target selection live outside this block. The block only sees the routed hard-level vector, a flag saying whether this processor is the current target, and the master-disable flag. Master disable silences the timer, the broadcast and the hard levels. It never silences software interrupts. The level lines are registered, so each line settles one clock after the state that requests it.

Top module: `cpu_irq_pend`

## Requirements
- R1: With `reg_addr` equal to 0, `reg_rdata` shows the pending word combinationally in the current cycle. Every other offset reads as 0.
- R2: A write to offset 2 ORs `reg_wdata[31:17]` into the software pending bits 31..17. The new bits are readable from the cycle after the write, and all other bits are untouched.
- R3: A write to offset 1 clears every software bit 31..17 and the broadcast bit 15 for which `reg_wdata` holds a 1. It never clears bit 14 or the hard-level bits.
- R4: Pending bit 14 equals `timer_i` in the same cycle. While `mst_dis_i` is 0, the timer requests level 14.
- R5: A rising edge of `bcast15_i` sets pending bit 15 and a falling edge clears it, each at the next clock edge. A rising edge wins over a clear write in the same cycle. While `mst_dis_i` is 0, bit 15 requests level 15.
- R6: Software pending bit 16+n requests level n, for n = 1..15.
- R7: While `mst_dis_i` is 1, only software bits request levels. The timer, the broadcast bit and the hard levels are suppressed in the outputs, but they still show in the pending word.
- R8: While `is_target_i` is 1, `hard_lvl_i[j]` is ORed into pending bit j and, if `mst_dis_i` is 0, requests level j (j = 1..15). While `is_target_i` is 0, hard levels neither show nor request.
- R9: `lvl_o[j]` is 1 exactly when level j was requested in the previous cycle. There is no level 0.
- R10: During reset, and in the first cycle after it with the inputs idle, the pending word reads 0 and every `lvl_o` line is 0.
- R11: Writes to offsets other than 1 and 2 change nothing. Bits 16..0 of the data for a set write are ignored, so bit 16 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Word offset of the register access |
| reg_wr | input | 1 | Write strobe for the offset in reg_addr |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| hard_lvl_i | input | NLVL | Routed hard level requests, bit j-1 is level j |
| is_target_i | input | 1 | This processor is the current routing target |
| mst_dis_i | input | 1 | Master disable from the system unit |
| timer_i | input | 1 | Local timer interrupt input |
| bcast15_i | input | 1 | Level-15 broadcast input |
| lvl_o | output | NLVL | Registered level requests, bit j-1 is level j |

## Verification
The hardest case is a rising broadcast edge in the same cycle as a clear write that selects bit 15. Only the ordering between the two decides the outcome. To reach it, the stimulus first raises and lowers the broadcast. Then it issues the clear write on exactly the cycle the broadcast rises again, and reads the pending word on the next cycle. A second hard case is a hard level that shows in the pending word while master disable holds its line low. This is reached by driving the target flag and master disable together and comparing the read data with the level lines in the same cycle.

// File: rtl/cpu_irq_pend_pkg.sv
package cpu_irq_pend_pkg;
   localparam int unsigned DEF_DATA_W  = 32;
   localparam int unsigned DEF_NLVL    = 15;
   localparam int unsigned DEF_SW_BASE = 16;
   localparam int unsigned DEF_ADDR_W  = 3;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_SET  = 2'd1,
      ACC_CLR  = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/cpu_irq_swreg.sv
module cpu_irq_swreg #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NLVL    = 15,
   parameter int unsigned SW_BASE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [NLVL:1]     sw_q
);
   localparam int unsigned TOP_BIT = SW_BASE + NLVL;

   initial begin : p_chk
      assert (TOP_BIT < DATA_W) else $fatal(1, "software field exceeds data width");
   end

   logic [NLVL:1] set_bits;
   logic [NLVL:1] clr_bits;
   logic [NLVL:1] sw_d;

   for (genvar n = 1; n <= NLVL; n++) begin : g_bit
      assign set_bits[n] = set_en & wdata[SW_BASE+n];
      assign clr_bits[n] = clr_en & wdata[SW_BASE+n];
      assign sw_d[n]     = (sw_q[n] & ~clr_bits[n]) | set_bits[n];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sw_q <= '0;
      else        sw_q <= sw_d;
   end

   assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> ((sw_q & $past(set_bits)) == $past(set_bits)));

   assert_clr_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en) |=> ((sw_q & $past(clr_bits)) == '0));

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en && !clr_en) |=> $stable(sw_q));
endmodule

// File: rtl/cpu_irq_bcast.sv
module cpu_irq_bcast (
   input  logic clk,
   input  logic rst_n,
   input  logic bcast_i,
   input  logic clr_en,
   output logic bit_q
);
   logic prev_q;
   logic rise;
   logic fall;

   assign rise = bcast_i & ~prev_q;
   assign fall = ~bcast_i & prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         bit_q  <= 1'b0;
      end else begin
         prev_q <= bcast_i;
         if (rise)        bit_q <= 1'b1;
         else if (fall)   bit_q <= 1'b0;
         else if (clr_en) bit_q <= 1'b0;
      end
   end

   assert_rise_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bcast_i && !prev_q) |=> bit_q);

   assert_fall_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bcast_i) |=> !bit_q);

   assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_en && (bcast_i == prev_q)) |=> $stable(bit_q));
endmodule

// File: rtl/cpu_irq_lvlenc.sv
module cpu_irq_lvlenc #(
   parameter int unsigned NLVL = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NLVL:1] sw_lvl,
   input  logic [NLVL:1] hard_lvl,
   input  logic          is_target,
   input  logic          mst_dis,
   input  logic          timer,
   input  logic          bcast_bit,
   output logic [NLVL:1] lvl_q
);
   localparam int unsigned TIMER_LVL = NLVL - 1;
   localparam int unsigned BCAST_LVL = NLVL;

   initial begin : p_chk
      assert (NLVL >= 2) else $fatal(1, "need at least two levels");
   end

   logic [NLVL:1] req;
   logic          gate;

   assign gate = ~mst_dis;

   for (genvar j = 1; j <= NLVL; j++) begin : g_lvl
      if (j == BCAST_LVL) begin : g_bc
         assign req[j] = sw_lvl[j] | (gate & (bcast_bit | (is_target & hard_lvl[j])));
      end else if (j == TIMER_LVL) begin : g_tm
         assign req[j] = sw_lvl[j] | (gate & (timer | (is_target & hard_lvl[j])));
      end else begin : g_hw
         assign req[j] = sw_lvl[j] | (gate & is_target & hard_lvl[j]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= req;
   end

   assert_sw_always_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((lvl_q & $past(sw_lvl)) == $past(sw_lvl)));

   assert_mdis_only_sw_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mst_dis |=> (lvl_q == $past(sw_lvl)));

   assert_nontarget_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_target && !timer && !bcast_bit) |=> (lvl_q == $past(sw_lvl)));
endmodule

// File: rtl/cpu_irq_pend.sv
module cpu_irq_pend
   import cpu_irq_pend_pkg::*;
#(
   parameter int unsigned DATA_W   = DEF_DATA_W,
   parameter int unsigned NLVL     = DEF_NLVL,
   parameter int unsigned SW_BASE  = DEF_SW_BASE,
   parameter int unsigned ADDR_W   = DEF_ADDR_W,
   parameter int unsigned OFS_READ = 0,
   parameter int unsigned OFS_CLR  = 1,
   parameter int unsigned OFS_SET  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NLVL:1]     hard_lvl_i,
   input  logic              is_target_i,
   input  logic              mst_dis_i,
   input  logic              timer_i,
   input  logic              bcast15_i,
   output logic [NLVL:1]     lvl_o
);
   localparam int unsigned TIMER_BIT = NLVL - 1;
   localparam int unsigned BCAST_BIT = NLVL;

   initial begin : p_chk
      assert (SW_BASE >= NLVL + 1) else $fatal(1, "software field overlaps levels");
      assert (SW_BASE + NLVL < DATA_W) else $fatal(1, "data width too small");
      assert (OFS_SET < (1 << ADDR_W)) else $fatal(1, "offset outside address range");
   end

   acc_kind_e     acc;
   logic [NLVL:1] sw_q;
   logic          bc_q;
   logic [DATA_W-1:0] pend;

   always_comb begin
      acc = ACC_NONE;
      if (reg_wr && (reg_addr == ADDR_W'(OFS_SET)))      acc = ACC_SET;
      else if (reg_wr && (reg_addr == ADDR_W'(OFS_CLR))) acc = ACC_CLR;
   end

   cpu_irq_swreg #(
      .DATA_W  (DATA_W),
      .NLVL    (NLVL),
      .SW_BASE (SW_BASE)
   ) u_swreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (acc == ACC_SET),
      .clr_en (acc == ACC_CLR),
      .wdata  (reg_wdata),
      .sw_q   (sw_q)
   );

   cpu_irq_bcast u_bcast (
      .clk     (clk),
      .rst_n   (rst_n),
      .bcast_i (bcast15_i),
      .clr_en  ((acc == ACC_CLR) && reg_wdata[BCAST_BIT]),
      .bit_q   (bc_q)
   );

   cpu_irq_lvlenc #(
      .NLVL (NLVL)
   ) u_lvlenc (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_lvl    (sw_q),
      .hard_lvl  (hard_lvl_i),
      .is_target (is_target_i),
      .mst_dis   (mst_dis_i),
      .timer     (timer_i),
      .bcast_bit (bc_q),
      .lvl_q     (lvl_o)
   );

   always_comb begin
      pend = '0;
      for (int n = 1; n <= int'(NLVL); n++) begin
         pend[SW_BASE+n] = sw_q[n];
         if (is_target_i) pend[n] = hard_lvl_i[n];
      end
      pend[TIMER_BIT] = pend[TIMER_BIT] | timer_i;
      pend[BCAST_BIT] = pend[BCAST_BIT] | bc_q;
   end

   assign reg_rdata = (reg_addr == ADDR_W'(OFS_READ)) ? pend : '0;

   assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (lvl_o == '0));

   assert_other_ofs_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr != ADDR_W'(OFS_READ)) |-> (reg_rdata == '0));
endmodule

// File: tb/cpu_irq_pend_bench.sv
module cpu_irq_pend_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [15:1] hard_lvl_i = '0;
   logic        is_target_i = 1'b0;
   logic        mst_dis_i = 1'b0;
   logic        timer_i = 1'b0;
   logic        bcast15_i = 1'b0;
   logic [15:1] lvl_o;

   always #(CLK_P/2) clk = ~clk;

   cpu_irq_pend u_cpu_irq_pend (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_addr    (reg_addr),
      .reg_wr      (reg_wr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .hard_lvl_i  (hard_lvl_i),
      .is_target_i (is_target_i),
      .mst_dis_i   (mst_dis_i),
      .timer_i     (timer_i),
      .bcast15_i   (bcast15_i),
      .lvl_o       (lvl_o)
   );

   typedef struct {
      string       tag;
      logic [31:0] rd;
      logic [15:1] lv;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   // requirement model
   logic [31:17] m_sw = '0;
   logic         m_bc = 1'b0;
   logic         m_prev = 1'b0;
   logic [15:1]  m_last = '0;

   function automatic logic [31:0] exp_pend();
      logic [31:0] p;
      if (reg_addr != 3'd0) return 32'h0;
      p = {m_sw, 1'b0, m_bc, timer_i, 14'b0};
      if (is_target_i) p = p | {16'b0, hard_lvl_i, 1'b0};
      return p;
   endfunction

   function automatic logic [15:1] exp_req();
      logic [15:1] r;
      r = m_sw;
      if (!mst_dis_i) begin
         r = r | {m_bc, timer_i, 13'b0};
         if (is_target_i) r = r | hard_lvl_i;
      end
      return r;
   endfunction

   task automatic tick(input string tag);
      exp_t it;
      logic [15:1] nr;
      it.tag = tag;
      it.rd  = exp_pend();
      it.lv  = m_last;
      q.push_back(it);
      if (!rst_n) begin
         m_sw = '0; m_bc = 1'b0; m_prev = 1'b0; m_last = '0;
      end else begin
         nr = exp_req();
         if (reg_wr && reg_addr == 3'd2) m_sw = m_sw | reg_wdata[31:17];
         if (reg_wr && reg_addr == 3'd1) begin
            m_sw = m_sw & ~reg_wdata[31:17];
            if (reg_wdata[15]) m_bc = 1'b0;
         end
         if (bcast15_i && !m_prev) m_bc = 1'b1;
         else if (!bcast15_i && m_prev) m_bc = 1'b0;
         m_prev = bcast15_i;
         m_last = nr;
      end
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
      reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
      tick(tag);
      reg_addr = 3'd0; reg_wr = 1'b0; reg_wdata = '0;
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         while (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            n_chk++;
            if (reg_rdata !== it.rd) begin
               n_bad++;
               $display("FAIL %s rdata act=%h exp=%h", it.tag, reg_rdata, it.rd);
            end
            n_chk++;
            if (lvl_o !== it.lv) begin
               n_bad++;
               $display("FAIL %s lvl act=%h exp=%h", it.tag, lvl_o, it.lv);
            end
         end
      end
   end

   initial begin
      #(CLK_P*20000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R10: reset state
      repeat (3) tick("R10 in reset");
      rst_n = 1'b1;
      tick("R10 after reset");
      tick("R10 idle");

      // R2 / R11: set writes, low bits ignored
      wr(3'd2, 32'hFFFF_FFFF, "R2 set all");
      tick("R2 R11 readback");
      tick("R6 levels from software");
      wr(3'd1, 32'hFFFE_0000, "R3 clear all");
      tick("R3 cleared");
      wr(3'd2, 32'h0002_0000, "R6 set level1");
      tick("R6 level1");
      wr(3'd2, 32'h8000_0000, "R6 set level15");
      tick("R6 level15");
      wr(3'd1, 32'h0002_4000, "R3 clear level1 and bit14");
      tick("R3 partial clear");

      // R11: other offsets
      wr(3'd3, 32'hFFFF_FFFF, "R11 write ofs3");
      wr(3'd0, 32'hFFFF_FFFF, "R11 write ofs0");
      tick("R11 no change");
      reg_addr = 3'd5;
      tick("R1 ofs5 reads zero");
      reg_addr = 3'd1;
      tick("R1 ofs1 reads zero");
      reg_addr = 3'd0;
      wr(3'd1, 32'hFFFF_FFFF, "R3 clear rest");
      tick("R3 empty");

      // R4 / R7: timer
      timer_i = 1'b1;
      tick("R4 timer shown");
      tick("R4 timer level14");
      mst_dis_i = 1'b1;
      tick("R7 timer masked");
      tick("R7 timer masked out");
      mst_dis_i = 1'b0;
      wr(3'd1, 32'h0000_4000, "R3 timer not clearable");
      tick("R4 timer still set");
      timer_i = 1'b0;
      tick("R4 timer drop");
      tick("R4 timer drop out");

      // R5: broadcast
      bcast15_i = 1'b1;
      tick("R5 rise");
      tick("R5 set");
      tick("R5 level15");
      wr(3'd1, 32'h0000_8000, "R3 clear bcast");
      tick("R3 bcast cleared");
      bcast15_i = 1'b0;
      tick("R5 fall");
      tick("R5 fall idle");
      bcast15_i = 1'b1;
      wr(3'd1, 32'h0000_8000, "R5 rise with clear");
      tick("R5 rise wins");
      mst_dis_i = 1'b1;
      tick("R7 bcast masked");
      tick("R7 bcast masked out");
      mst_dis_i = 1'b0;
      bcast15_i = 1'b0;
      tick("R5 fall clears");
      tick("R5 quiet");

      // R8: hard levels
      hard_lvl_i = 15'h5555;
      tick("R8 not target");
      tick("R8 not target out");
      is_target_i = 1'b1;
      tick("R8 target shown");
      tick("R8 target levels");
      mst_dis_i = 1'b1;
      wr(3'd2, 32'h0004_0000, "R7 sw under mdis");
      tick("R7 hard shown masked");
      tick("R7 sw only");
      mst_dis_i = 1'b0;
      hard_lvl_i = 15'h2AAA;
      tick("R8 new pattern");
      tick("R9 registered out");
      is_target_i = 1'b0;
      tick("R8 target dropped");
      tick("R9 lvl follows");
      hard_lvl_i = '0;
      wr(3'd1, 32'hFFFF_FFFF, "R3 final clear");
      tick("R9 final");
      tick("R9 settled");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule